// File: doc/BRIEF.md
# Scrambled NRZI serial line encoder

The block turns a stream of 10-bit parallel words into a single serial line. A word is captured in a holding register whenever the load strobe is high. On each serial bit period, marked by a one-cycle bit enable, the shifter puts out one bit, least significant first. After every tenth bit period it reloads from the holding register, so the serial rate is exactly ten bits per parallel word.

The raw bit stream is scrambled by a self-synchronizing divider with polynomial x^9+x^4+1. The scrambler's output is then coded NRZI with polynomial x+1: a one toggles the line and a zero leaves it where it was. The line is driven on a true/complement pair. A lock input and a test-mode input together decide whether that pair carries data. When lock is absent or test mode is on, the pair sits at an idle level with the true side high and the complement side low. The scrambler and NRZI state keep running while the output is idle.

A monitor output gives the bit rate divided by ten. It is high for the first five bit periods of each word.

Top module: `scr_nrzi_encoder`

## Requirements
- R1: `word_in` is captured while `word_ld` is high. At the first `bit_en` after reset, and at every tenth `bit_en` after that, the captured word moves into the shifter. The first serial bit after reset is a zero, and the bits of the loaded words follow it.
- R2: Each word goes out least significant bit first, one bit per `bit_en`.
- R3: Each scrambled bit is the raw bit XOR the scrambled bits from 4 and from 9 bit periods earlier. The scrambler history resets to all zeros.
- R4: The NRZI line toggles on a scrambled one and holds on a scrambled zero. The line resets to 0, so `ser_p` is 0 after reset once the output is enabled.
- R5: While enabled, `ser_n` is the complement of `ser_p`. Decoding `ser_n` alone (NRZI decode, then multiply by x^9+x^4+1) recovers the same data as decoding `ser_p`.
- R6: One clock after `lock_in` goes low, `ser_p` is 1 and `ser_n` is 0. They stay there until one clock after lock comes back.
- R7: `test_mode` high forces the same idle pair as a missing lock, one clock later.
- R8: Scrambler and NRZI state advance on every `bit_en` even while the output is idle. Once the output is re-enabled, the line equals what an uninterrupted encoder would send, and a receiver's descrambler recovers correct data after at most 10 bits.
- R9: `div_mon` is high for the first five bit periods of each word and low for the last five. Before the first `bit_en` after reset it is low.
- R10: While reset is held, `ser_p`=1, `ser_n`=0 and `div_mon`=0.
- R11: A clock without `bit_en` advances nothing: `ser_p` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit period per high cycle |
| word_in | input | 10 | Parallel data word |
| word_ld | input | 1 | Captures word_in into the holding register |
| lock_in | input | 1 | Clock lock status; low idles the output |
| test_mode | input | 1 | High disables input and idles the output |
| ser_p | output | 1 | Serial line, true side |
| ser_n | output | 1 | Serial line, complement side |
| div_mon | output | 1 | Bit rate divided by ten |

## Verification
The assertions check on every cycle that the idle pair appears whenever the gate is closed and that the pair is complementary while it is open. They also check that the line toggles exactly on a scrambled one, that the scrambler history takes each new output bit, and that the bit counter neither moves without a bit enable nor misses its wrap at a word load. The bench's scenarios cover the properties that span many cycles: LSB-first framing across whole words, and recovery of the data through an independent descrambler on either side of the pair. They also show that the line matches an uninterrupted encoder after a lock loss or a test-mode period, and that the divide-by-ten monitor follows the word phase.

// File: rtl/scr_nrzi_pkg.sv
package scr_nrzi_pkg;
  // Scrambled bit from a raw bit and the history (hist[0] newest).
  function automatic logic scr_bit(input logic raw, input logic [8:0] hist,
                                   input int tap_a, input int tap_b);
    return raw ^ hist[tap_a-1] ^ hist[tap_b-1];
  endfunction

  // NRZI next line level: a one toggles, a zero holds.
  function automatic logic nrzi_next(input logic line, input logic b);
    return line ^ b;
  endfunction
endpackage

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WORD_W = 10,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_ld,
  output logic              ser_bit,
  output logic              word_load,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              phase_mark
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] shift_q;

  assign word_load  = bit_en && (bit_cnt == LAST);
  assign ser_bit    = shift_q[0];
  assign phase_mark = (bit_cnt < HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (word_ld) hold_q <= word_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      bit_cnt <= LAST;
    end else if (bit_en) begin
      if (bit_cnt == LAST) begin
        shift_q <= hold_q;
        bit_cnt <= '0;
      end else begin
        shift_q <= shift_q >> 1;
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sync_scrambler.sv
module sync_scrambler #(
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               din,
  output logic               dout,
  output logic [SCR_LEN-1:0] state
);
  import scr_nrzi_pkg::*;

  assign dout = scr_bit(din, 9'(state), SCR_TAP, SCR_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else if (step) state <= {state[SCR_LEN-2:0], dout};
  end
endmodule

// File: rtl/nrzi_gate.sv
module nrzi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic din,
  input  logic lock_ok,
  output logic ser_p,
  output logic ser_n,
  output logic line_q,
  output logic gate_q
);
  import scr_nrzi_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= lock_ok;
      if (step) line_q <= nrzi_next(line_q, din);
    end
  end

  assign ser_p = gate_q ? line_q  : 1'b1;
  assign ser_n = gate_q ? ~line_q : 1'b0;
endmodule

// File: rtl/scr_nrzi_encoder.sv
module scr_nrzi_encoder #(
  parameter int WORD_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_ld,
  input  logic              lock_in,
  input  logic              test_mode,
  output logic              ser_p,
  output logic              ser_n,
  output logic              div_mon
);
  logic               raw_bit;
  logic               word_load;
  logic [CNT_W-1:0]   bit_cnt;
  logic               scr_out;
  logic [SCR_LEN-1:0] scr_state;
  logic               line_q;
  logic               gate_q;
  logic               lock_ok;

  assign lock_ok = lock_in && !test_mode;

  word_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_in(word_in),
    .word_ld(word_ld), .ser_bit(raw_bit), .word_load(word_load),
    .bit_cnt(bit_cnt), .phase_mark(div_mon)
  );

  sync_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .din(raw_bit),
    .dout(scr_out), .state(scr_state)
  );

  nrzi_gate u_out (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .din(scr_out),
    .lock_ok(lock_ok), .ser_p(ser_p), .ser_n(ser_n),
    .line_q(line_q), .gate_q(gate_q)
  );
endmodule

// File: rtl/scr_nrzi_encoder_chk.sv
module scr_nrzi_encoder_chk #(
  parameter int SCR_LEN = 9,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_en,
  input logic               lock_in,
  input logic               test_mode,
  input logic               ser_p,
  input logic               ser_n,
  input logic               gate_q,
  input logic               line_q,
  input logic               scr_out,
  input logic [SCR_LEN-1:0] scr_state,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               word_load
);
  // R6: a missing lock gives the idle pair one clock later
  a_r6_idle_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> (ser_p && !ser_n));

  // R7: test mode idles the pair one clock later
  a_r7_test_idle: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (ser_p && !ser_n));

  // R5: the enabled pair is complementary
  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (ser_n != ser_p));

  // R4: a scrambled one toggles the line
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && scr_out) |=> (line_q != $past(line_q)));

  // R4: a scrambled zero holds the line
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !scr_out) |=> $stable(line_q));

  // R3 R8: the history takes every scrambled bit, gated or not
  a_r3_history: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (scr_state[0] == $past(scr_out)));

  // R11: no bit enable, no advance
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_cnt) && $stable(line_q) && $stable(scr_state)));

  // R1: a word load restarts the bit phase
  a_r1_load_phase: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |=> (bit_cnt == '0));
endmodule

bind scr_nrzi_encoder scr_nrzi_encoder_chk #(.SCR_LEN(SCR_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock_in(lock_in),
  .test_mode(test_mode), .ser_p(ser_p), .ser_n(ser_n), .gate_q(gate_q),
  .line_q(line_q), .scr_out(scr_out), .scr_state(scr_state),
  .bit_cnt(bit_cnt), .word_load(word_load)
);

// File: tb/scr_nrzi_encoder_tb.sv
`timescale 1ns/100ps
module scr_nrzi_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [9:0] word_in = '0;
  logic       word_ld = 1'b0;
  logic       lock_in = 1'b1;
  logic       test_mode = 1'b0;
  logic       ser_p, ser_n, div_mon;

  int checks = 0;
  int fails = 0;
  bit reported = 0;
  bit in_reset = 1'b1;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  scr_nrzi_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_in(word_in),
    .word_ld(word_ld), .lock_in(lock_in), .test_mode(test_mode),
    .ser_p(ser_p), .ser_n(ser_n), .div_mon(div_mon)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  endtask

  // Driver: one word per call, with optional stall cycles between bits
  task automatic send_word(input logic [9:0] w, input int gap);
    @(negedge clk);
    word_in = w;
    word_ld = 1'b1;
    for (int i = 0; i < 10; i++) exp_q.push_back(w[i]);
    @(negedge clk);
    word_ld = 1'b0;
    for (int i = 0; i < 10; i++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  // Monitor state: reference encoder and two receivers
  logic [8:0] ref_h = '0;   // ref_h[8] newest scrambled bit
  logic       ref_line = 1'b0;
  logic       pa_prev = 1'b0, pn_prev = 1'b1;
  logic [8:0] da_h = '0, dn_h = '0;  // [0] newest NRZ bit
  int         skip = 0;
  int         nbits = 0;
  logic       last_p = 1'b1;
  bit         gate_prev = 1'b0;

  always @(posedge clk) begin
    bit en_edge, gate_exp, r, b, nz_a, nz_n, ra, rn;
    en_edge  = bit_en && !in_reset;
    gate_exp = lock_in && !test_mode && !in_reset;
    if (en_edge) begin
      nbits++;
      if (exp_q.size() == 0) begin
        r = 1'b0;
        check(1'b0, "R1 queue", 0, 1);
      end else r = exp_q.pop_front();
      b = r ^ ref_h[5] ^ ref_h[0];
      ref_h = {b, ref_h[8:1]};
      ref_line = ref_line ^ b;
    end
    #1;
    if (!in_reset) begin
      if (!gate_exp)
        check(ser_p && !ser_n, test_mode ? "R7 idle pair" : "R6 idle pair",
              {ser_p, ser_n}, 2);
      else if (en_edge) begin
        check(ser_p == ref_line, "R4 R8 line vs reference", ser_p, ref_line);
        check(ser_n == !ser_p, "R5 complement", ser_n, !ser_p);
      end
      if (!en_edge && gate_exp == gate_prev && !word_ld)
        check(ser_p == last_p, "R11 stall hold", ser_p, last_p);
      if (en_edge) begin
        check(div_mon == (((nbits - 1) % 10) < 5), "R9 div monitor",
              div_mon, (((nbits - 1) % 10) < 5));
        nz_a = ser_p ^ pa_prev; pa_prev = ser_p;
        nz_n = ser_n ^ pn_prev; pn_prev = ser_n;
        ra = nz_a ^ da_h[3] ^ da_h[8]; da_h = {da_h[7:0], nz_a};
        rn = nz_n ^ dn_h[3] ^ dn_h[8]; dn_h = {dn_h[7:0], nz_n};
        if (!gate_exp) skip = 10;
        else if (skip > 0) skip--;
        else begin
          check(ra == r, "R1 R2 R3 descrambled true side", ra, r);
          check(rn == r, "R5 descrambled complement side", rn, r);
        end
      end
      last_p = ser_p;
      gate_prev = gate_exp;
    end
  end

  initial begin
    logic [9:0] lf;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ser_p == 1'b1 && ser_n == 1'b0, "R10 reset pair", {ser_p, ser_n}, 2);
    check(div_mon == 1'b0, "R10 reset div", div_mon, 0);
    @(negedge clk);
    rst_n = 1'b1;
    in_reset = 1'b0;
    exp_q.push_back(1'b0);  // R1: dummy first bit
    @(negedge clk);
    @(negedge clk);
    check(div_mon == 1'b0, "R9 before first bit", div_mon, 0);
    check(ser_p == 1'b0, "R4 line after reset", ser_p, 0);
    // all-zero words: line must stay at 0 (R3 R4)
    for (int k = 0; k < 3; k++) send_word(10'h000, 0);
    check(ser_p == 1'b0, "R3 R4 zero data quiet line", ser_p, 0);
    send_word(10'h3FF, 0); send_word(10'h000, 0); send_word(10'h000, 0);
    send_word(10'h155, 1); send_word(10'h2AA, 0);
    for (int k = 0; k < 10; k++) send_word(10'(1 << k), (k == 4) ? 2 : 0);
    lf = 10'h2C7;
    for (int k = 0; k < 12; k++) begin
      lf = {lf[8:0], lf[9] ^ lf[6]};
      send_word(lf, k % 3);
    end
    // R6 R8: lock loss then recovery
    lock_in = 1'b0;
    for (int k = 0; k < 3; k++) send_word(10'h1E3 + 10'(k), 0);
    lock_in = 1'b1;
    for (int k = 0; k < 5; k++) send_word(10'h0F0 ^ 10'(k * 37), 0);
    // R7: test mode
    test_mode = 1'b1;
    for (int k = 0; k < 3; k++) send_word(10'h33C, 1);
    test_mode = 1'b0;
    for (int k = 0; k < 5; k++) send_word(10'h2D1 + 10'(k * 91), 0);
    send_word(10'h000, 0);  // flush
    repeat (4) @(negedge clk);
    report();
  end

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    report();
  end
endmodule